// File: doc/BRIEF.md
# Serial-Controlled SAR Converter Sequencer

This block is the digital control for an 8-bit successive-approximation converter on the device side of a three-wire serial link. The host pulls chip select low and clocks the link. It sends a start bit and then a two-bit multiplexer address. The block steers a two-input analog multiplexer, gives one clock of settling, and runs a binary search: it drives a trial code into the ladder DAC and reads back a single comparator bit on each rising clock edge.

Each result bit goes out on the serial output as soon as it is decided, most significant bit first. The word is then sent again least significant bit first, with bit 0 shared between the two streams. The serial output changes only on falling clock edges, so the host can sample it on rising edges. The output is tri-stated whenever the block is not driving it. The data input is ignored once the address is taken, so the data input and output can share one wire. Raising chip select clears everything at once.

Top module: `sar_seq_top`

States: IDLE waits for the start bit. ADDR takes the two address bits. SETTLE is the settling slot. CONV makes the eight decisions. TAIL re-sends bits 1 to 7. DONE holds the output in high impedance.

Transitions:
- IDLE to ADDR when the data input is sampled high.
- ADDR to SETTLE on the second address bit.
- SETTLE to CONV after one clock.
- CONV to TAIL after bit 0 is decided.
- TAIL to DONE after bit 7 is re-sent.
- Any state to IDLE while chip select is high.

## Requirements
- R1: While `cs_n` is high, `dout_oe`, `trial_code`, `mux_single` and `mux_odd` are all 0. Raising `cs_n` in the middle of a transaction clears them at once, without waiting for a clock edge.
- R2: After `cs_n` falls, the start bit is the first 1 sampled on `din` at a rising `sclk` edge. Any 0s sampled before it are ignored, and `dout_oe` stays 0 while they arrive.
- R3: The two `din` bits after the start bit form the address. The first is the single/differential bit (1 = single-ended) and the second is the odd bit. They appear on `mux_single` and `mux_odd` from the rising edge that samples the second bit. The decode is:
  - single=1, odd=0: CH0 against ground.
  - single=1, odd=1: CH1 against ground.
  - single=0, odd=0: CH0 positive, CH1 negative.
  - single=0, odd=1: CH1 positive, CH0 negative.
- R4: Count rising edges from the start bit, which is edge 1. After falling edge 4 (the one that follows rising edge 4), `dout_oe` is 1 and `dout` is 0 for one whole clock period. This is the settling slot.
- R5: On rising edge 4, `trial_code` loads with only its most significant bit set (0x80).
- R6: On each of rising edges 5 to 12, one bit is decided, from bit 7 down to bit 0. The bit under test is kept if `cmp_ge` is 1 and cleared if it is 0, and the next lower bit is set. After edge 12, `trial_code` holds the result.
- R7: Each decided bit is driven on `dout` from the falling edge right after its decision. Falling edges 5 to 12 therefore carry bits 7 down to 0.
- R8: Falling edges 13 to 19 carry result bits 1 up to 7. From falling edge 20, `dout_oe` is 0 and stays 0 while `cs_n` stays low.
- R9: After the second address bit, `din` is ignored until `cs_n` rises: it cannot change the mux selects, the result or `dout`. A new transaction needs `cs_n` to go high and then low again.
- R10: If the positive input is below the negative input, the comparator never reports high, and the result on `dout` and `trial_code` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cs_n | input | 1 | Chip select, active low; high clears the block asynchronously |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data input (start bit and address) |
| cmp_ge | input | 1 | Comparator: 1 when the selected input is at or above the trial level |
| dout | output | 1 | Serial data output value |
| dout_oe | output | 1 | Output enable for the serial data pad; 0 means high impedance |
| trial_code | output | 8 | Trial code driving the ladder DAC; holds the result at the end |
| mux_single | output | 1 | 1 = single-ended, 0 = differential |
| mux_odd | output | 1 | 1 = CH1 is the positive input, 0 = CH0 is the positive input |

## Verification
Two single-ended sweeps cover every 8-bit input value on each channel. The other channel holds an unrelated value, so a wrong channel select shows up as a wrong code. Differential transactions in both polarities use input pairs with positive, zero and negative differences. This separates a swapped polarity from a correct one, and exercises the all-zero result. Varying leading zeros, random data input during conversion, an abort partway through, and extra clocks after the tail cover start detection, input masking, immediate clearing and the return to high impedance.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_SETTLE,
        S_CONV,
        S_TAIL,
        S_DONE
    } seq_state_e;

endpackage

// File: rtl/sar_trial_reg.sv
// Binary-search register: loads the MSB, then decides one bit per step.
module sar_trial_reg #(
    parameter int RES_W = 8,
    localparam int IW   = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             load,
    input  logic             step,
    input  logic [IW-1:0]    idx,
    input  logic             cmp_ge,
    output logic [RES_W-1:0] trial
);

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            trial <= '0;
        end else if (load) begin
            trial <= {1'b1, {(RES_W-1){1'b0}}};
        end else if (step) begin
            for (int b = 0; b < RES_W; b++) begin
                if (b == int'(idx)) begin
                    trial[b] <= cmp_ge;
                end else if (b + 1 == int'(idx)) begin
                    trial[b] <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sar_dout_stage.sv
// Falling-edge retiming of the serial output and its enable.
module sar_dout_stage (
    input  logic clk,
    input  logic clr,
    input  logic emit_en,
    input  logic emit_val,
    output logic dout,
    output logic dout_oe
);

    always_ff @(negedge clk or posedge clr) begin
        if (clr) begin
            dout    <= 1'b0;
            dout_oe <= 1'b0;
        end else begin
            dout    <= emit_en & emit_val;
            dout_oe <= emit_en;
        end
    end

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top #(
    parameter int RES_W = 8
) (
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             din,
    input  logic             cmp_ge,
    output logic             dout,
    output logic             dout_oe,
    output logic [RES_W-1:0] trial_code,
    output logic             mux_single,
    output logic             mux_odd
);
    import sar_seq_pkg::*;

    localparam int IW = $clog2(RES_W);
    localparam logic [IW-1:0] TOP_IDX = IW'(RES_W - 1);

    seq_state_e    state_q;
    seq_state_e    state_d;
    logic [IW-1:0] cnt_q;
    logic          addr_second_q;
    logic          single_hold_q;
    logic          emit_en_q;
    logic          emit_val_q;

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (din) state_d = S_ADDR;
            S_ADDR:   if (addr_second_q) state_d = S_SETTLE;
            S_SETTLE: state_d = S_CONV;
            S_CONV:   if (cnt_q == '0) state_d = S_TAIL;
            S_TAIL:   if (cnt_q == TOP_IDX) state_d = S_DONE;
            S_DONE:   state_d = S_DONE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge sclk or posedge cs_n) begin
        if (cs_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // per-state outputs and counters
    always_ff @(posedge sclk or posedge cs_n) begin
        if (cs_n) begin
            cnt_q         <= '0;
            addr_second_q <= 1'b0;
            single_hold_q <= 1'b0;
            mux_single    <= 1'b0;
            mux_odd       <= 1'b0;
            emit_en_q     <= 1'b0;
            emit_val_q    <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    addr_second_q <= 1'b0;
                end
                S_ADDR: begin
                    if (!addr_second_q) begin
                        single_hold_q <= din;
                        addr_second_q <= 1'b1;
                    end else begin
                        mux_single <= single_hold_q;
                        mux_odd    <= din;
                    end
                end
                S_SETTLE: begin
                    emit_en_q  <= 1'b1;
                    emit_val_q <= 1'b0;
                    cnt_q      <= TOP_IDX;
                end
                S_CONV: begin
                    emit_val_q <= cmp_ge;
                    cnt_q      <= (cnt_q == '0) ? IW'(1) : cnt_q - 1'b1;
                end
                S_TAIL: begin
                    emit_val_q <= trial_code[cnt_q];
                    if (cnt_q != TOP_IDX) cnt_q <= cnt_q + 1'b1;
                end
                S_DONE: begin
                    emit_en_q <= 1'b0;
                end
                default: begin
                    emit_en_q <= 1'b0;
                end
            endcase
        end
    end

    sar_trial_reg #(.RES_W(RES_W)) u_trial (
        .clk    (sclk),
        .clr    (cs_n),
        .load   (state_q == S_SETTLE),
        .step   (state_q == S_CONV),
        .idx    (cnt_q),
        .cmp_ge (cmp_ge),
        .trial  (trial_code)
    );

    sar_dout_stage u_dout (
        .clk      (sclk),
        .clr      (cs_n),
        .emit_en  (emit_en_q),
        .emit_val (emit_val_q),
        .dout     (dout),
        .dout_oe  (dout_oe)
    );

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk
    import sar_seq_pkg::*;
#(
    parameter int RES_W = 8
) (
    input logic             sclk,
    input logic             cs_n,
    input logic             dout,
    input logic             dout_oe,
    input logic [RES_W-1:0] trial_code,
    input logic             mux_single,
    input logic             mux_odd,
    input seq_state_e       state_q
);

    // R2: nothing driven and no trial code before the address is complete
    a_r2_quiet_before_start: assert property (@(posedge sclk) disable iff (cs_n)
        (state_q == S_IDLE || state_q == S_ADDR) |-> (!dout_oe && trial_code == '0));

    // R4: the first driven period of the output is a low
    a_r4_settle_low: assert property (@(negedge sclk) disable iff (cs_n)
        $rose(dout_oe) |-> !dout);

    // R5: the settling edge leaves only the MSB set
    a_r5_msb_load: assert property (@(posedge sclk) disable iff (cs_n)
        (state_q == S_SETTLE) |=> (trial_code == {1'b1, {(RES_W-1){1'b0}}}));

    // R9: mux selects frozen once conversion runs
    a_r9_mux_hold: assert property (@(posedge sclk) disable iff (cs_n)
        (state_q == S_CONV || state_q == S_TAIL || state_q == S_DONE)
        |=> ($stable(mux_single) && $stable(mux_odd)));

    // R8: output released after the tail
    a_r8_hiz_after_tail: assert property (@(posedge sclk) disable iff (cs_n)
        (state_q == S_DONE && $past(state_q) == S_DONE) |-> !dout_oe);

endmodule

bind sar_seq_top sar_seq_chk #(.RES_W(RES_W)) u_chk (
    .sclk       (sclk),
    .cs_n       (cs_n),
    .dout       (dout),
    .dout_oe    (dout_oe),
    .trial_code (trial_code),
    .mux_single (mux_single),
    .mux_odd    (mux_odd),
    .state_q    (state_q)
);

// File: tb/sim_sar_seq_top.sv
`timescale 1ns/1ps
module sim_sar_seq_top;

    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       din = 1'b0;
    logic       cmp_ge;
    logic       dout;
    logic       dout_oe;
    logic [7:0] trial_code;
    logic       mux_single;
    logic       mux_odd;

    int a0 = 0;
    int a1 = 0;
    int tests = 0;
    int fails = 0;

    sar_seq_top #(.RES_W(8)) u0 (
        .cs_n(cs_n), .sclk(sclk), .din(din), .cmp_ge(cmp_ge),
        .dout(dout), .dout_oe(dout_oe), .trial_code(trial_code),
        .mux_single(mux_single), .mux_odd(mux_odd)
    );

    always #5 sclk = ~sclk;

    // analog front end model: selected difference compared with trial level
    always_comb begin
        int pos;
        int neg;
        pos = mux_odd ? a1 : a0;
        neg = mux_single ? 0 : (mux_odd ? a0 : a1);
        cmp_ge = (pos - neg) >= int'(trial_code);
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int expect_code(input bit sgl, input bit odd, input int v0, input int v1);
        int d;
        d = sgl ? (odd ? v1 : v0) : (odd ? v1 - v0 : v0 - v1);
        if (d < 0) d = 0;
        if (d > 255) d = 255;
        return d;
    endfunction

    task automatic step_neg();
        @(negedge sclk);
        #2;
    endtask

    task automatic txn(input int lz, input bit sgl, input bit odd, input int v0, input int v1);
        int e;
        a0 = v0;
        a1 = v1;
        e = expect_code(sgl, odd, v0, v1);
        @(negedge sclk);
        cs_n = 1'b0;
        for (int i = 0; i < lz; i++) begin
            din = 1'b0;
            step_neg();
            chk("R2 hi-z before start", int'(dout_oe), 0);
        end
        din = 1'b1;
        step_neg();
        din = sgl;
        step_neg();
        din = odd;
        step_neg();
        chk("R2 hi-z during address", int'(dout_oe), 0);
        chk("R3 single bit", int'(mux_single), int'(sgl));
        chk("R3 odd bit", int'(mux_odd), int'(odd));
        din = 1'($urandom);
        step_neg();
        chk("R4 settle enable", int'(dout_oe), 1);
        chk("R4 settle low", int'(dout), 0);
        chk("R5 msb load", int'(trial_code), 128);
        for (int k = 7; k >= 0; k--) begin
            din = 1'($urandom);
            step_neg();
            chk("R7 msb-first enable", int'(dout_oe), 1);
            chk("R7 msb-first bit", int'(dout), (e >> k) & 1);
        end
        chk("R6 final code", int'(trial_code), e);
        if (e == 0) chk("R10 zero result", int'(trial_code), 0);
        for (int k = 1; k <= 7; k++) begin
            din = 1'($urandom);
            step_neg();
            chk("R8 lsb-first bit", int'(dout), (e >> k) & 1);
        end
        for (int i = 0; i < 3; i++) begin
            din = 1'b1;
            step_neg();
            chk("R8 hi-z after tail", int'(dout_oe), 0);
        end
        chk("R9 no restart", int'(trial_code), e);
        chk("R9 mux single held", int'(mux_single), int'(sgl));
        chk("R9 mux odd held", int'(mux_odd), int'(odd));
        cs_n = 1'b1;
        #1;
        chk("R1 clear oe", int'(dout_oe), 0);
        chk("R1 clear trial", int'(trial_code), 0);
        chk("R1 clear mux", int'(mux_single) + int'(mux_odd), 0);
        din = 1'b0;
    endtask

    task automatic abort_txn();
        @(negedge sclk);
        cs_n = 1'b0;
        a0 = 200;
        a1 = 17;
        din = 1'b1;
        step_neg();
        din = 1'b1;
        step_neg();
        din = 1'b1;
        for (int i = 0; i < 6; i++) step_neg();
        chk("R1 active before abort", int'(dout_oe), 1);
        cs_n = 1'b1;
        #1;
        chk("R1 abort oe", int'(dout_oe), 0);
        chk("R1 abort trial", int'(trial_code), 0);
        chk("R1 abort mux", int'(mux_single) + int'(mux_odd), 0);
        din = 1'b0;
        repeat (2) @(negedge sclk);
    endtask

    initial begin
        #1_900_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge sclk);
        #2;
        chk("R1 reset oe", int'(dout_oe), 0);
        chk("R1 reset trial", int'(trial_code), 0);
        // R3 single-ended CH0, every value
        for (int v = 0; v < 256; v++) txn(v % 4, 1'b1, 1'b0, v, 255 - v);
        // R3 single-ended CH1, every value
        for (int v = 0; v < 256; v++) txn(0, 1'b1, 1'b1, (v * 7) % 256, v);
        // R3 / R10 differential, both polarities, positive and negative differences
        for (int i = 0; i < 64; i++) begin
            int p;
            int q;
            p = (i * 37) % 256;
            q = (i * 91 + 13) % 256;
            txn(i % 3, 1'b0, 1'b0, p, q);
            txn(0, 1'b0, 1'b1, p, q);
        end
        txn(1, 1'b0, 1'b0, 10, 200);   // R10 negative difference
        txn(0, 1'b0, 1'b1, 90, 90);    // R10 zero difference
        abort_txn();                   // R1 mid-transaction clear
        txn(5, 1'b1, 1'b0, 165, 0);    // recovery after abort
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule